// File: doc/BRIEF.md
# Page Table Entry Fill Engine

This engine writes a contiguous run of 64-bit page table entries into a table held in memory. A single start pulse supplies the first entry index, the number of entries, the physical base address, the memory type, the access attributes, the page-size shift, an optional stolen-memory base and a compression tag base. The engine then emits the entries as pairs of 32-bit word writes on a valid/ready write port and raises a one-cycle done pulse when the last word has been accepted.

The run is cut into groups. Each group is the largest power-of-two count, from 1 to 128 entries, that both fits in the entries still to be written and is aligned at the current entry index. Every entry in a group carries the same word pair, with the group exponent stamped into it. The physical address and a compression delta advance once per group. Compressed memory types also get a per-group tag in the high word.

An unmap mode writes zero words over the same run of entries. Software uses the engine by programming the inputs, pulsing start and waiting for done.

Top module: `pte_fill_engine`

## Requirements
- R1: Entry n of the run is written as two words: the low word at byte address 8·n and then the high word at byte address 8·n+4. The low word is always accepted before the high word, and entries are written in ascending index order.
- R2: In a mapped entry, low-word bit 0 is 1 and bit 6 equals the system-memory flag. Bit 3 is 1 unless the write-only flag is set. The 64-bit entry value also carries the physical address ORed in at bit 0 and the memory type ORed in at bit 40, which is high-word bit 8.
- R3: When the stolen-memory base is nonzero, it is added to the physical base (modulo 2^PA_W) and the 2-bit target field at low-word bits 5:4 is 3. When the base is zero, the target field is 0 and the address is used as given.
- R4: Each group has 2^e entries. The exponent e is the largest value in 0..7 for which 2^e is at most the remaining count and the current entry index is a multiple of 2^e. The value e appears at low-word bits 9:7, and every entry of a group has identical words.
- R5: After each group, the physical address used for the next group grows by 2^(e+page_shift).
- R6: The compression mode is memory-type bits 8:7. When it is nonzero, high-word bits 31:17 hold (tag_base + (delta>>16)·mode) mod 2^15. Delta is 0 for the first group and grows by the same amount as the address after each group. When the mode is zero, those bits come only from the entry value.
- R7: In unmap mode, every word written is zero, and the number and addresses of the writes are the same as in map mode.
- R8: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values.
- R9: busy rises in the cycle after start and stays high until the last word is accepted. done is high for exactly one cycle right after that, with busy low. A start pulse while busy has no effect on the run.
- R10: A start with a zero count issues no write and gives a done pulse in the next cycle.
- R11: After reset, busy, done and wr_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latches all run inputs when idle |
| unmap | input | 1 | 1: clear entries, 0: map |
| first_idx | input | IDX_W | First entry index |
| entry_cnt | input | CNT_W | Number of entries |
| phys_base | input | PA_W | Physical address of the first page |
| mem_type | input | MT_W | Memory type; bits 8:7 select compression |
| sys_access | input | 1 | Mapping targets system memory |
| write_only | input | 1 | Mapping is write-only |
| page_shift | input | SHIFT_W | log2 of page size in bytes |
| stolen_base | input | PA_W | Stolen-memory base, 0 when unused |
| tag_base | input | TAG_W | First compression tag |
| wr_valid | output | 1 | Write request |
| wr_addr | output | IDX_W+3 | Byte address in the table |
| wr_data | output | 32 | Word to write |
| wr_ready | input | 1 | Memory accepts the write |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check that write requests hold steady while stalled, that a high word follows each accepted low word at the same entry, that every chosen group fits and is aligned, that unmap words are zero, that mapped low words are present, and that done is a single pulse. The full contents of each word cannot be checked by a property. This covers the target code under stolen memory, the stamped exponent, the address and delta advance across groups and the compression tag arithmetic. The bench compares every write against a model of its own, using directed group boundaries, stall patterns, a start issued mid-run and seeded random runs.

// File: rtl/pte_fill_pkg.sv
// Package: shared types for the page table entry fill engine.
// Assumes: group exponents never exceed 7 (at most 128 entries per group).
package pte_fill_pkg;
    localparam int EXP_W   = 3;
    localparam int EXP_MAX = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GROUP,
        ST_LO,
        ST_HI,
        ST_FIN
    } fill_state_t;
endpackage

// File: rtl/pte_group_sel.sv
// Module: picks the exponent of the next entry group.
// Returns the largest e in 0..EXP_MAX with 2^e <= remaining count and the
// index aligned to 2^e. Assumes CNT_W > EXP_MAX and a nonzero count.
module pte_group_sel
    import pte_fill_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] remain,
    output logic [EXP_W-1:0] grp_exp
);
    // Ascending scan: the last size that fits and is aligned wins.
    always_comb begin
        grp_exp = '0;
        for (int e = 0; e <= EXP_MAX; e++) begin
            if (remain >= (CNT_W'(1) << e) &&
                (idx & IDX_W'((1 << e) - 1)) == '0)
                grp_exp = EXP_W'(e);
        end
    end
endmodule

// File: rtl/pte_word_gen.sv
// Module: builds the low/high word pair of one entry for the current group.
// Assumes: MT_W >= 9 and 40 + MT_W <= 64; TAG_W <= 15 so the tag fits at bit 17.
module pte_word_gen
    import pte_fill_pkg::*;
#(
    parameter int PA_W  = 40,
    parameter int MT_W  = 9,
    parameter int TAG_W = 15
) (
    input  logic [PA_W-1:0]  pa,
    input  logic [MT_W-1:0]  mem_type,
    input  logic [1:0]       target,
    input  logic             sys_access,
    input  logic             write_only,
    input  logic [EXP_W-1:0] grp_exp,
    input  logic [TAG_W-1:0] tag_base,
    input  logic [PA_W-1:0]  delta,
    input  logic             unmap,
    output logic [31:0]      word_lo,
    output logic [31:0]      word_hi
);
    logic [63:0]      ent;
    logic [1:0]       comp;
    logic [PA_W-1:0]  prod;
    logic [TAG_W-1:0] tag;

    // Entry value with flags, target and memory type merged in.
    always_comb begin
        ent = 64'(pa) | (64'(mem_type) << 40) | (64'(target) << 4) | 64'd1;
        if (sys_access) ent[6] = 1'b1;
        if (!write_only) ent[3] = 1'b1;
    end

    // Per-group compression tag from the running delta.
    always_comb begin
        comp = mem_type[8:7];
        prod = (delta >> 16) * PA_W'(comp);
        tag  = tag_base + TAG_W'(prod);
    end

    // Final word pair, forced to zero for unmap.
    always_comb begin
        word_lo = ent[31:0] | (32'(grp_exp) << 7);
        word_hi = ent[63:32];
        if (comp != 2'd0) word_hi = word_hi | (32'(tag) << 17);
        if (unmap) begin
            word_lo = '0;
            word_hi = '0;
        end
    end
endmodule

// File: rtl/pte_fill_engine.sv
// Module: top of the page table entry fill engine.
// Latches a run on start, cuts it into aligned power-of-two groups and
// writes each entry as a low then high word on a valid/ready port.
// Assumes: first_idx + entry_cnt stays inside the table; wr_ready may stall.
module pte_fill_engine
    import pte_fill_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int CNT_W   = 16,
    parameter int PA_W    = 40,
    parameter int MT_W    = 9,
    parameter int TAG_W   = 15,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               unmap,
    input  logic [IDX_W-1:0]   first_idx,
    input  logic [CNT_W-1:0]   entry_cnt,
    input  logic [PA_W-1:0]    phys_base,
    input  logic [MT_W-1:0]    mem_type,
    input  logic               sys_access,
    input  logic               write_only,
    input  logic [SHIFT_W-1:0] page_shift,
    input  logic [PA_W-1:0]    stolen_base,
    input  logic [TAG_W-1:0]   tag_base,
    output logic               wr_valid,
    output logic [IDX_W+2:0]   wr_addr,
    output logic [31:0]        wr_data,
    input  logic               wr_ready,
    output logic               busy,
    output logic               done
);
    localparam int TBL_AW = IDX_W + 3;
    localparam int GRP_W  = EXP_MAX + 2;
    localparam int SH_W   = SHIFT_W + 1;

    fill_state_t        state;
    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [GRP_W-1:0]   grp_q;
    logic [PA_W-1:0]    pa_q;
    logic [PA_W-1:0]    delta_q;
    logic [31:0]        lo_q;
    logic [31:0]        hi_q;
    logic               unmap_q;
    logic [MT_W-1:0]    mt_q;
    logic [1:0]         tgt_q;
    logic               sys_q;
    logic               wo_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [TAG_W-1:0]   tagb_q;

    logic [EXP_W-1:0]   grp_exp;
    logic [31:0]        gen_lo;
    logic [31:0]        gen_hi;
    logic [SH_W-1:0]    adv_sh;
    logic [PA_W-1:0]    adv;

    pte_group_sel #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_sel (
        .idx     (idx_q),
        .remain  (cnt_q),
        .grp_exp (grp_exp)
    );

    pte_word_gen #(.PA_W(PA_W), .MT_W(MT_W), .TAG_W(TAG_W)) u_gen (
        .pa         (pa_q),
        .mem_type   (mt_q),
        .target     (tgt_q),
        .sys_access (sys_q),
        .write_only (wo_q),
        .grp_exp    (grp_exp),
        .tag_base   (tagb_q),
        .delta      (delta_q),
        .unmap      (unmap_q),
        .word_lo    (gen_lo),
        .word_hi    (gen_hi)
    );

    // Per-group advance of the address and the compression delta.
    always_comb begin
        adv_sh = SH_W'(grp_exp) + SH_W'(shift_q);
        adv    = PA_W'(1) << adv_sh;
    end

    // Sequencer: latch, plan group, write low word, write high word, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            grp_q   <= '0;
            pa_q    <= '0;
            delta_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            unmap_q <= 1'b0;
            mt_q    <= '0;
            tgt_q   <= '0;
            sys_q   <= 1'b0;
            wo_q    <= 1'b0;
            shift_q <= '0;
            tagb_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx_q   <= first_idx;
                        cnt_q   <= entry_cnt;
                        delta_q <= '0;
                        unmap_q <= unmap;
                        mt_q    <= mem_type;
                        sys_q   <= sys_access;
                        wo_q    <= write_only;
                        shift_q <= page_shift;
                        tagb_q  <= tag_base;
                        if (stolen_base != '0) begin
                            pa_q  <= phys_base + stolen_base;
                            tgt_q <= 2'd3;
                        end else begin
                            pa_q  <= phys_base;
                            tgt_q <= 2'd0;
                        end
                        state <= (entry_cnt == '0) ? ST_FIN : ST_GROUP;
                    end
                end
                ST_GROUP: begin
                    lo_q    <= gen_lo;
                    hi_q    <= gen_hi;
                    grp_q   <= GRP_W'(1) << grp_exp;
                    cnt_q   <= cnt_q - (CNT_W'(1) << grp_exp);
                    pa_q    <= pa_q + adv;
                    delta_q <= delta_q + adv;
                    state   <= ST_LO;
                end
                ST_LO: begin
                    if (wr_ready) state <= ST_HI;
                end
                ST_HI: begin
                    if (wr_ready) begin
                        idx_q <= idx_q + 1'b1;
                        grp_q <= grp_q - 1'b1;
                        if (grp_q != GRP_W'(1)) state <= ST_LO;
                        else if (cnt_q == '0)   state <= ST_FIN;
                        else                    state <= ST_GROUP;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the sequencer state.
    always_comb begin
        wr_valid = (state == ST_LO) || (state == ST_HI);
        wr_addr  = {idx_q, (state == ST_HI), 2'b00};
        wr_data  = (state == ST_HI) ? hi_q : lo_q;
        busy     = (state == ST_GROUP) || wr_valid;
        done     = (state == ST_FIN);
    end

    // A stalled request keeps its address and data.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // An accepted low word is followed by the high word of the same entry.
    p_hi_after_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && !wr_addr[2] |=>
        wr_valid && wr_addr[2] && wr_addr[TBL_AW-1:3] == $past(wr_addr[TBL_AW-1:3]));

    // Chosen group fits in the remaining count and is aligned at the index.
    p_group_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GROUP |->
        (CNT_W'(1) << grp_exp) <= cnt_q &&
        (idx_q & ((IDX_W'(1) << grp_exp) - IDX_W'(1))) == '0);

    // Unmap writes only zero words.
    p_unmap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && unmap_q |-> wr_data == 32'd0);

    // Mapped low words carry the present bit.
    p_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !unmap_q && !wr_addr[2] |-> wr_data[0]);

    // done is a single-cycle pulse with busy low.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);

    // A zero-count start completes in the next cycle without writes.
    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !done && entry_cnt == '0 |=> done && !wr_valid);
endmodule

// File: tb/test_pte_fill_engine.sv
// Bench: directed corner cases plus seeded random runs, every write checked
// against a model computed here from the requirements.
module test_pte_fill_engine;
    localparam int IDX_W = 16, CNT_W = 16, PA_W = 40, MT_W = 9, TAG_W = 15, SHIFT_W = 5;
    localparam int MAXW  = 4096;
    localparam logic [PA_W-1:0] PA_MASK = '1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               unmap = 1'b0;
    logic [IDX_W-1:0]   first_idx = '0;
    logic [CNT_W-1:0]   entry_cnt = '0;
    logic [PA_W-1:0]    phys_base = '0;
    logic [MT_W-1:0]    mem_type = '0;
    logic               sys_access = 1'b0;
    logic               write_only = 1'b0;
    logic [SHIFT_W-1:0] page_shift = 5'd12;
    logic [PA_W-1:0]    stolen_base = '0;
    logic [TAG_W-1:0]   tag_base = '0;
    logic               wr_valid;
    logic [IDX_W+2:0]   wr_addr;
    logic [31:0]        wr_data;
    logic               wr_ready = 1'b1;
    logic               busy;
    logic               done;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int ngot = 0;
    int nexp = 0;
    logic [IDX_W+2:0] got_addr [MAXW];
    logic [31:0]      got_data [MAXW];
    logic [IDX_W+2:0] exp_addr [MAXW];
    logic [31:0]      exp_data [MAXW];

    pte_fill_engine i_pte_fill_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .unmap(unmap),
        .first_idx(first_idx), .entry_cnt(entry_cnt), .phys_base(phys_base),
        .mem_type(mem_type), .sys_access(sys_access), .write_only(write_only),
        .page_shift(page_shift), .stolen_base(stolen_base), .tag_base(tag_base),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    // Ready pattern changes just after each rising edge.
    always @(posedge clk) begin
        #1;
        wr_ready = (rdy_mode == 0) ? 1'b1 : 1'($urandom % 2);
    end

    // Record every accepted write at the falling edge.
    always @(negedge clk) begin
        if (wr_valid && wr_ready && ngot < MAXW) begin
            got_addr[ngot] = wr_addr;
            got_data[ngot] = wr_data;
            ngot++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // Model of the expected write sequence for the latched inputs.
    task automatic build_expected();
        logic [PA_W-1:0] pa;
        logic [PA_W-1:0] dl;
        logic [1:0]      tgt;
        int              idx, rem, e;
        logic [63:0]     ent;
        logic [31:0]     lo, hi;
        logic [PA_W-1:0] prod;
        logic [1:0]      comp;
        logic [TAG_W-1:0] tag;
        nexp = 0;
        pa  = (stolen_base != 0) ? PA_W'(phys_base + stolen_base) : phys_base;
        tgt = (stolen_base != 0) ? 2'd3 : 2'd0;
        dl  = '0;
        idx = int'(first_idx);
        rem = int'(entry_cnt);
        comp = mem_type[8:7];
        while (rem > 0) begin
            e = 0;
            for (int k = 0; k < 8; k++)
                if (rem >= (1 << k) && (idx % (1 << k)) == 0) e = k;
            ent = 64'(pa) | (64'(mem_type) << 40) | (64'(tgt) << 4) | 64'd1
                | (sys_access ? 64'h40 : 64'h0) | (write_only ? 64'h0 : 64'h8);
            lo = ent[31:0] | (32'(e) << 7);
            hi = ent[63:32];
            if (comp != 0) begin
                prod = (dl >> 16) * PA_W'(comp);
                tag  = tag_base + TAG_W'(prod);
                hi   = hi | (32'(tag) << 17);
            end
            if (unmap) begin lo = 0; hi = 0; end
            for (int k = 0; k < (1 << e); k++) begin
                exp_addr[nexp] = (IDX_W+3)'(idx * 8);     exp_data[nexp] = lo; nexp++;
                exp_addr[nexp] = (IDX_W+3)'(idx * 8 + 4); exp_data[nexp] = hi; nexp++;
                idx++;
            end
            rem -= (1 << e);
            pa = (pa + (PA_W'(1) << (e + int'(page_shift)))) & PA_MASK;
            dl = (dl + (PA_W'(1) << (e + int'(page_shift)))) & PA_MASK;
        end
    endtask

    // One run: start, optionally poke start mid-run, wait for done, compare.
    task automatic run_case(input string req, input int mode, input bit poke);
        int wait_cyc;
        build_expected();
        rdy_mode = mode;
        ngot = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (entry_cnt != 0)
            check(busy == 1'b1, "R9 busy after start", busy, 1);
        else
            check(done == 1'b1 && ngot == 0, "R10 zero count done", done, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            unmap = ~unmap; entry_cnt = entry_cnt + 5;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cyc = 0;
        while (!done && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(done == 1'b1, "R9 done reached", done, 1);
        check(busy == 1'b0, "R9 busy low at done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", done, 0);
        check(ngot == nexp, {req, " write count"}, ngot, nexp);
        for (int k = 0; k < nexp && k < ngot; k++) begin
            check(got_addr[k] == exp_addr[k], {req, " R1 address"}, got_addr[k], exp_addr[k]);
            check(got_data[k] == exp_data[k], {req, " data"}, got_data[k], exp_data[k]);
        end
        rdy_mode = 0;
    endtask

    task automatic set_run(input bit um, input int idx, input int cnt, input logic [PA_W-1:0] pa,
                           input int mt, input bit sys, input bit wo, input int sh,
                           input logic [PA_W-1:0] stl, input int tb);
        unmap = um; first_idx = IDX_W'(idx); entry_cnt = CNT_W'(cnt); phys_base = pa;
        mem_type = MT_W'(mt); sys_access = sys; write_only = wo; page_shift = SHIFT_W'(sh);
        stolen_base = stl; tag_base = TAG_W'(tb);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && wr_valid == 0, "R11 reset state",
              {busy, done, wr_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        set_run(0, 0, 1, 40'h12_3456_7000, 9'h05, 1, 0, 12, 0, 0);
        run_case("R2 single entry flags", 0, 0);
        set_run(0, 9, 2, 40'h00_0010_0000, 9'h0a, 0, 1, 12, 0, 0);
        run_case("R2 write-only", 0, 0);
        set_run(0, 3, 21, 40'h00_4000_0000, 9'h00, 0, 0, 12, 0, 0);
        run_case("R4 unaligned start", 0, 0);
        set_run(0, 0, 256, 40'h00_0000_0000, 9'h11, 1, 0, 16, 0, 0);
        run_case("R5 two full groups", 0, 0);
        set_run(0, 128, 200, 40'h01_0000_0000, 9'h00, 0, 0, 12, 40'h00_8000_0000, 0);
        run_case("R3 stolen base", 0, 0);
        set_run(0, 0, 300, 40'h00_2000_0000, 9'h100, 0, 0, 16, 0, 15'h7ff0);
        run_case("R6 compression mode 2", 0, 0);
        set_run(0, 5, 90, 40'h00_0300_0000, 9'h1ff, 1, 1, 12, 0, 15'h0123);
        run_case("R6 compression mode 3", 0, 0);
        set_run(1, 7, 50, 40'h00_0300_0000, 9'h1ff, 1, 0, 12, 40'h1000, 3);
        run_case("R7 unmap", 1, 0);
        set_run(0, 60, 70, 40'h0f_0000_0000, 9'h080, 0, 0, 12, 0, 9);
        run_case("R8 stalled port", 1, 0);
        set_run(0, 0, 0, 40'h0, 9'h0, 0, 0, 12, 0, 0);
        run_case("R10 zero count", 0, 0);
        set_run(0, 32, 40, 40'h00_0500_0000, 9'h03, 0, 0, 12, 0, 0);
        run_case("R9 start while busy", 1, 1);

        for (int n = 0; n < 12; n++) begin
            set_run(1'($urandom % 8 == 0), int'($urandom % 1000), 1 + int'($urandom % 300),
                    {8'($urandom), 20'($urandom), 12'h000}, int'($urandom % 512),
                    1'($urandom % 2), 1'($urandom % 2), ($urandom % 2) ? 16 : 12,
                    ($urandom % 2) ? {8'd0, 20'($urandom), 12'h000} : 40'd0,
                    int'($urandom % 32768));
            run_case("R4 R5 R6 random run", int'($urandom % 2), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule